// File: doc/BRIEF.md
# Memory Attribute Remap Unit

This block turns the memory attributes found in a page-table entry into the attributes the memory system actually applies. A 3-bit index is formed as {TEX[0], C, B}. Two 32-bit remap registers, a primary one and a normal one, define what each of the eight index values means.

The lookup has two stages and no clock in its path. In the first stage the index picks a 2-bit memory type out of the primary register. The type is strongly ordered, device or normal. A shareable bit is then chosen from the primary register, based on that type and on the page-table S bit. In the second stage, a normal result picks up inner and outer cacheability from the normal register. Any other type carries non-cacheable attributes. A global enable switches remapping off entirely, and the outputs then say that nothing was remapped.

Software reaches the two registers through a coprocessor-style access port. The port carries opcode and register-number fields and a privilege flag. The port answers in the same cycle, with read data, an undefined-instruction fault, or a "not decoded" flag. A privileged write lands at the next clock edge. The block has no state machine: its only state is the two registers.

Top module: `mem_attr_remap`

## Requirements
- R1: With remapping enabled, the memory type comes from primary-register bits [2i+1:2i], where i = {TEX[0],C,B}. The type encoding is 00 strongly ordered, 01 device, 10 normal. A programmed 11 is reported as 10 (normal).
- R2: The shareable output is 1 for a strongly ordered type. For a device type it is primary bit 16 when S=0 and bit 17 when S=1. For a normal type it is bit 18 when S=0 and bit 19 when S=1.
- R3: For a normal type, the inner attribute is normal-register bits [2i+1:2i] and the outer attribute is bits [2i+17:2i+16]. For any other type, both attributes are 00. The attribute encoding is 00 non-cacheable, 01 write-back with write allocate, 10 write-through, 11 write-back without write allocate.
- R4: An inner field that holds 01 is reported as 11. An outer field that holds 01 is reported unchanged.
- R5: When remap_en is 0, the remapped flag is 0 and the type, shareable, inner and outer outputs are all 0. When remap_en is 1, the remapped flag is 1.
- R6: After reset, the primary register reads 0x00098AA4 and the normal register reads 0x44E048E0. This is the identity mapping.
- R7: An access decodes only when op1=0, CRn=10 and CRm=2. Within that group, op2=0 selects the primary register and op2=1 selects the normal register. Any other valid access raises acc_nodec, returns 0 on acc_rdata and changes no register.
- R8: A privileged read returns the selected register on acc_rdata in the same cycle. A privileged write updates the selected register at the next rising clock edge.
- R9: A decoded access with acc_priv=0, whether a read or a write, raises acc_undef, returns 0 on acc_rdata and leaves both registers unchanged.
- R10: The primary register holds bits [19:0] only, and bits [31:20] always read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| acc_op1 | input | 3 | First opcode field |
| acc_crn | input | 4 | Primary register-number field |
| acc_crm | input | 4 | Secondary register-number field |
| acc_op2 | input | 3 | Second opcode field, selects the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, 0 unless a privileged read decodes |
| acc_undef | output | 1 | Undefined-instruction fault for a user-mode access |
| acc_nodec | output | 1 | Access does not match the register encoding |
| lk_index | input | 3 | Page-table index {TEX[0],C,B} |
| lk_shared | input | 1 | Page-table S bit |
| remap_en | input | 1 | Global remap enable |
| attr_type | output | 2 | Remapped memory type |
| attr_shared | output | 1 | Remapped shareable bit |
| attr_inner | output | 2 | Remapped inner cacheability |
| attr_outer | output | 2 | Remapped outer cacheability |
| attr_remapped | output | 1 | 1 when remapping was applied |

## Verification
Some properties are checked on every cycle. The reported type never reads 11. A strongly ordered result is always shareable. A non-normal result never carries cache attributes, and an inner attribute of 01 never appears. With remapping disabled, every attribute output is 0. A faulted or undecoded access never moves a register, and the port never raises two of its responses at once.

Other behaviours only the bench scenarios can show. These are that each index reaches its own field, that S picks the correct shareable bit, that the reset values give the identity mapping, and that read-back after writes is exact, including the zeroed upper bits of the primary register.

// File: rtl/mar_pkg.sv
package mar_pkg;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned IDX_W      = 3;
    localparam int unsigned FLD_W      = 2;
    localparam int unsigned N_IDX      = 1 << IDX_W;
    localparam int unsigned OUTER_OFS  = N_IDX * FLD_W;
    localparam int unsigned SHR_OFS    = N_IDX * FLD_W;
    localparam int unsigned PRI_LIVE_W = SHR_OFS + 4;

    localparam logic [REG_W-1:0] PRI_RST = 32'h0009_8AA4;
    localparam logic [REG_W-1:0] NRM_RST = 32'h44E0_48E0;

    typedef enum logic [1:0] {
        MT_STRONG = 2'b00,
        MT_DEVICE = 2'b01,
        MT_NORMAL = 2'b10,
        MT_ALIAS  = 2'b11
    } mem_type_e;

    typedef enum logic [1:0] {
        CA_NONE  = 2'b00,
        CA_WB_WA = 2'b01,
        CA_WT    = 2'b10,
        CA_WB    = 2'b11
    } cache_attr_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_PRI  = 2'b01,
        SEL_NRM  = 2'b10
    } reg_sel_e;
endpackage

// File: rtl/mar_decode.sv
module mar_decode
    import mar_pkg::*;
#(
    parameter int unsigned OP_W = 3,
    parameter int unsigned CR_W = 4,
    parameter logic [OP_W-1:0] OP1_HIT = 3'd0,
    parameter logic [CR_W-1:0] CRN_HIT = 4'd10,
    parameter logic [CR_W-1:0] CRM_HIT = 4'd2,
    parameter logic [OP_W-1:0] OP2_PRI = 3'd0,
    parameter logic [OP_W-1:0] OP2_NRM = 3'd1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            write,
    input  logic            priv,
    input  logic [OP_W-1:0] op1,
    input  logic [CR_W-1:0] crn,
    input  logic [CR_W-1:0] crm,
    input  logic [OP_W-1:0] op2,
    output reg_sel_e        sel,
    output logic            wr_en,
    output logic            rd_en,
    output logic            undef,
    output logic            nodec
);
    logic grp_hit;
    logic known;

    always_comb begin
        grp_hit = (op1 == OP1_HIT) && (crn == CRN_HIT) && (crm == CRM_HIT);
        sel     = SEL_NONE;
        if (grp_hit) begin
            if (op2 == OP2_PRI)      sel = SEL_PRI;
            else if (op2 == OP2_NRM) sel = SEL_NRM;
        end
        known = (sel != SEL_NONE);
        nodec = valid && !known;
        undef = valid && known && !priv;
        wr_en = valid && known && priv && write;
        rd_en = valid && known && priv && !write;
    end

    assert_port_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nodec, undef, wr_en, rd_en}));

    assert_user_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !priv && sel != SEL_NONE) |-> (undef && !wr_en && !rd_en));
endmodule

// File: rtl/mar_regfile.sv
module mar_regfile
    import mar_pkg::*;
#(
    parameter logic [REG_W-1:0] PRI_RESET = PRI_RST,
    parameter logic [REG_W-1:0] NRM_RESET = NRM_RST
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  reg_sel_e              sel,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  blocked,
    input  logic [REG_W-1:0]      wdata,
    output logic [PRI_LIVE_W-1:0] pri_q,
    output logic [REG_W-1:0]      nrm_q,
    output logic [REG_W-1:0]      rdata
);
    localparam int unsigned PAD_W = REG_W - PRI_LIVE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_q <= PRI_RESET[PRI_LIVE_W-1:0];
            nrm_q <= NRM_RESET;
        end else if (wr_en) begin
            unique case (sel)
                SEL_PRI: pri_q <= wdata[PRI_LIVE_W-1:0];
                SEL_NRM: nrm_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_PRI: rdata = {{PAD_W{1'b0}}, pri_q};
                SEL_NRM: rdata = nrm_q;
                default: rdata = '0;
            endcase
        end
    end

    assert_blocked_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> ($stable(pri_q) && $stable(nrm_q)));

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NRM) |=> (nrm_q == $past(wdata)));

    assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_PRI) |-> (rdata[REG_W-1:PRI_LIVE_W] == '0));
endmodule

// File: rtl/mar_lookup.sv
module mar_lookup
    import mar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PRI_LIVE_W-1:0] pri_q,
    input  logic [REG_W-1:0]      nrm_q,
    input  logic [IDX_W-1:0]      idx,
    input  logic                  shr_in,
    input  logic                  enable,
    output logic [FLD_W-1:0]      type_o,
    output logic                  shared_o,
    output logic [FLD_W-1:0]      inner_o,
    output logic [FLD_W-1:0]      outer_o,
    output logic                  remapped_o
);
    logic [FLD_W-1:0] typ_tab [N_IDX];
    logic [FLD_W-1:0] inr_tab [N_IDX];
    logic [FLD_W-1:0] otr_tab [N_IDX];

    for (genvar g = 0; g < N_IDX; g++) begin : g_field
        assign typ_tab[g] = pri_q[g*FLD_W +: FLD_W];
        assign inr_tab[g] = nrm_q[g*FLD_W +: FLD_W];
        assign otr_tab[g] = nrm_q[OUTER_OFS + g*FLD_W +: FLD_W];
    end

    logic [1:0]  dev_pair;
    logic [1:0]  nrm_pair;
    mem_type_e   stage1;
    logic        shr_sel;
    cache_attr_e in_sel;
    cache_attr_e out_sel;

    assign dev_pair = pri_q[SHR_OFS +: 2];
    assign nrm_pair = pri_q[SHR_OFS + 2 +: 2];

    // Stage 1: memory type and shareability
    always_comb begin
        unique case (mem_type_e'(typ_tab[idx]))
            MT_STRONG: stage1 = MT_STRONG;
            MT_DEVICE: stage1 = MT_DEVICE;
            default:   stage1 = MT_NORMAL;
        endcase
        unique case (stage1)
            MT_STRONG: shr_sel = 1'b1;
            MT_DEVICE: shr_sel = dev_pair[shr_in];
            default:   shr_sel = nrm_pair[shr_in];
        endcase
    end

    // Stage 2: cacheability, only for normal memory
    always_comb begin
        in_sel  = CA_NONE;
        out_sel = CA_NONE;
        if (stage1 == MT_NORMAL) begin
            in_sel  = cache_attr_e'(inr_tab[idx]);
            out_sel = cache_attr_e'(otr_tab[idx]);
            if (in_sel == CA_WB_WA) in_sel = CA_WB;
        end
    end

    always_comb begin
        remapped_o = enable;
        type_o     = enable ? stage1  : '0;
        shared_o   = enable ? shr_sel : 1'b0;
        inner_o    = enable ? in_sel  : '0;
        outer_o    = enable ? out_sel : '0;
    end

    assert_type_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        remapped_o |-> (type_o != MT_ALIAS));

    assert_strong_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (remapped_o && type_o == MT_STRONG) |-> shared_o);

    assert_cache_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (remapped_o && type_o != MT_NORMAL) |-> (inner_o == '0 && outer_o == '0));

    assert_inner_noalloc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        remapped_o |-> (inner_o != CA_WB_WA));

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!remapped_o && type_o == '0 && !shared_o && inner_o == '0 && outer_o == '0));
endmodule

// File: rtl/mem_attr_remap.sv
module mem_attr_remap
    import mar_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic        acc_priv,
    input  logic [2:0]  acc_op1,
    input  logic [3:0]  acc_crn,
    input  logic [3:0]  acc_crm,
    input  logic [2:0]  acc_op2,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        acc_undef,
    output logic        acc_nodec,
    input  logic [2:0]  lk_index,
    input  logic        lk_shared,
    input  logic        remap_en,
    output logic [1:0]  attr_type,
    output logic        attr_shared,
    output logic [1:0]  attr_inner,
    output logic [1:0]  attr_outer,
    output logic        attr_remapped
);
    reg_sel_e              sel;
    logic                  wr_en;
    logic                  rd_en;
    logic [PRI_LIVE_W-1:0] pri_q;
    logic [REG_W-1:0]      nrm_q;

    mar_decode u_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (acc_valid),
        .write (acc_write),
        .priv  (acc_priv),
        .op1   (acc_op1),
        .crn   (acc_crn),
        .crm   (acc_crm),
        .op2   (acc_op2),
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .undef (acc_undef),
        .nodec (acc_nodec)
    );

    mar_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .blocked (acc_undef || acc_nodec),
        .wdata   (acc_wdata),
        .pri_q   (pri_q),
        .nrm_q   (nrm_q),
        .rdata   (acc_rdata)
    );

    mar_lookup u_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .pri_q      (pri_q),
        .nrm_q      (nrm_q),
        .idx        (lk_index),
        .shr_in     (lk_shared),
        .enable     (remap_en),
        .type_o     (attr_type),
        .shared_o   (attr_shared),
        .inner_o    (attr_inner),
        .outer_o    (attr_outer),
        .remapped_o (attr_remapped)
    );
endmodule

// File: tb/mem_attr_remap_tb.sv
module mem_attr_remap_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_priv = 1'b0;
    logic [2:0]  acc_op1 = '0, acc_op2 = '0;
    logic [3:0]  acc_crn = '0, acc_crm = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_undef, acc_nodec;
    logic [2:0]  lk_index = '0;
    logic        lk_shared = 1'b0, remap_en = 1'b0;
    logic [1:0]  attr_type, attr_inner, attr_outer;
    logic        attr_shared, attr_remapped;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_attr_remap u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_priv(acc_priv),
        .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_undef(acc_undef), .acc_nodec(acc_nodec),
        .lk_index(lk_index), .lk_shared(lk_shared), .remap_en(remap_en),
        .attr_type(attr_type), .attr_shared(attr_shared),
        .attr_inner(attr_inner), .attr_outer(attr_outer),
        .attr_remapped(attr_remapped)
    );

    typedef struct packed {
        logic [1:0]  t;
        logic        sh;
        logic [1:0]  in;
        logic [1:0]  out;
        logic        rem;
        logic [31:0] rd;
        logic        und;
        logic        nod;
    } obs_t;

    obs_t  exp_q [$];
    string tag_q [$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic [31:0] mdl_pri = 32'h0009_8AA4;
    logic [31:0] mdl_nrm = 32'h44E0_48E0;

    task automatic step(input logic v, input logic w, input logic p,
                        input logic [2:0] op1, input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] op2, input logic [31:0] wd,
                        input logic [2:0] idx, input logic s, input logic en, input string tag);
        obs_t e;
        logic hit;
        logic [1:0] raw, ty, ci;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_priv = p;
        acc_op1 = op1; acc_crn = crn; acc_crm = crm; acc_op2 = op2; acc_wdata = wd;
        lk_index = idx; lk_shared = s; remap_en = en;
        hit   = (op1 == 3'd0) && (crn == 4'd10) && (crm == 4'd2) && (op2 <= 3'd1);
        e     = '0;
        e.nod = v && !hit;
        e.und = v && hit && !p;
        if (v && hit && p && !w) e.rd = (op2 == 3'd0) ? {12'h000, mdl_pri[19:0]} : mdl_nrm;
        if (en) begin
            raw   = mdl_pri[2*idx +: 2];
            ty    = (raw == 2'b11) ? 2'b10 : raw;
            e.rem = 1'b1;
            e.t   = ty;
            if (ty == 2'b00)      e.sh = 1'b1;
            else if (ty == 2'b01) e.sh = mdl_pri[16 + s];
            else                  e.sh = mdl_pri[18 + s];
            if (ty == 2'b10) begin
                ci    = mdl_nrm[2*idx +: 2];
                e.in  = (ci == 2'b01) ? 2'b11 : ci;
                e.out = mdl_nrm[16 + 2*idx +: 2];
            end
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (v && hit && p && w) begin
            if (op2 == 3'd0) mdl_pri = wd & 32'h000F_FFFF;
            else             mdl_nrm = wd;
        end
    endtask

    task automatic look(input logic [2:0] idx, input logic s, input logic en, input string tag);
        step(1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 4'd0, 3'd0, 32'h0, idx, s, en, tag);
    endtask

    task automatic acc(input logic w, input logic p, input logic [2:0] op1, input logic [3:0] crn,
                       input logic [3:0] crm, input logic [2:0] op2, input logic [31:0] wd,
                       input string tag);
        step(1'b1, w, p, op1, crn, crm, op2, wd, 3'd0, 1'b0, 1'b1, tag);
    endtask

    // Monitor: compares one expected item per cycle, a little after the falling edge
    initial begin
        obs_t  act, e;
        string tag;
        forever begin
            @(negedge clk);
            #3;
            if (exp_q.size() != 0) begin
                e   = exp_q.pop_front();
                tag = tag_q.pop_front();
                act = {attr_type, attr_shared, attr_inner, attr_outer, attr_remapped,
                       acc_rdata, acc_undef, acc_nodec};
                n_cmp++;
                if (act !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual=%h expected=%h (type,sh,in,out,rem,rdata,undef,nodec)",
                             tag, act, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        acc(1'b0, 1'b1, 3'd0, 4'd10, 4'd2, 3'd0, 32'h0, "R6 reset primary readback");
        acc(1'b0, 1'b1, 3'd0, 4'd10, 4'd2, 3'd1, 32'h0, "R6 reset normal readback");

        for (int i = 0; i < 8; i++) begin
            look(3'(i), 1'b0, 1'b1, "R1 R2 R3 R4 reset lookup S=0");
            look(3'(i), 1'b1, 1'b1, "R1 R2 R3 R4 reset lookup S=1");
        end

        look(3'd3, 1'b1, 1'b0, "R5 disabled lookup");
        look(3'd7, 1'b0, 1'b0, "R5 disabled lookup");

        acc(1'b1, 1'b0, 3'd0, 4'd10, 4'd2, 3'd0, 32'hFFFF_FFFF, "R9 user write primary");
        acc(1'b0, 1'b0, 3'd0, 4'd10, 4'd2, 3'd1, 32'h0, "R9 user read normal");
        acc(1'b0, 1'b1, 3'd0, 4'd10, 4'd2, 3'd0, 32'h0, "R9 primary unchanged");

        acc(1'b1, 1'b1, 3'd0, 4'd10, 4'd3, 3'd0, 32'h1234_5678, "R7 wrong crm");
        acc(1'b1, 1'b1, 3'd0, 4'd10, 4'd2, 3'd2, 32'h1234_5678, "R7 wrong op2");
        acc(1'b0, 1'b1, 3'd1, 4'd10, 4'd2, 3'd1, 32'h0, "R7 wrong op1 read");
        acc(1'b0, 1'b1, 3'd0, 4'd9,  4'd2, 3'd0, 32'h0, "R7 wrong crn read");
        acc(1'b0, 1'b1, 3'd0, 4'd10, 4'd2, 3'd1, 32'h0, "R7 normal unchanged");

        acc(1'b1, 1'b1, 3'd0, 4'd10, 4'd2, 3'd0, 32'hFFF6_E41B, "R8 write primary");
        acc(1'b0, 1'b1, 3'd0, 4'd10, 4'd2, 3'd0, 32'h0, "R10 primary upper bits zero");
        acc(1'b1, 1'b1, 3'd0, 4'd10, 4'd2, 3'd1, 32'h5A5A_5555, "R8 write normal");
        acc(1'b0, 1'b1, 3'd0, 4'd10, 4'd2, 3'd1, 32'h0, "R8 normal readback");

        for (int i = 0; i < 8; i++) begin
            look(3'(i), 1'b0, 1'b1, "R1 R2 R3 R4 programmed lookup S=0");
            look(3'(i), 1'b1, 1'b1, "R1 R2 R3 R4 programmed lookup S=1");
        end

        for (int k = 0; k < 120; k++) begin
            logic [31:0] r;
            r = $urandom();
            step(r[0], r[1], r[2] | r[3], r[4] ? 3'd1 : 3'd0, r[5] ? 4'd11 : 4'd10,
                 r[6] ? 4'd1 : 4'd2, {1'b0, r[8] & r[9], r[7]}, $urandom(),
                 r[12:10], r[13], r[14] | r[15], "R1 R2 R3 R4 R5 R7 R8 R9 R10 random");
        end

        @(negedge clk);
        acc_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule